// File: doc/BRIEF.md
# Four-Channel DMA Request/Acknowledge Arbiter

This block sits between the DMA request lines of several peripherals and the acknowledge lines that answer them. The request inputs arrive without any timing relation to the block clock. Each one passes through a synchronizer and then through a polarity stage, so the arbiter only ever works with active-high requests. The arbiter then grants exactly one channel at a time. Among the channels that are waiting, the lowest channel number always wins.

Two command-register bits set the levels at the pins, and they can be changed at run time. One bit tells the block whether requests are asserted high or low. The other bit sets the level at which an acknowledge is driven when it is asserted.

A grant normally lasts until the datapath signals that the transfer is complete. When the timing mode is not compatible mode, a fairness timer runs while a channel holds its grant. If the timer has reached its limit and another channel is waiting, the grant is withdrawn and the channel is marked as having an unfinished transfer. That mark stays set until the channel wins a later arbitration and completes its transfer.

Top module: `dma_handshake_arb`

## Requirements
- R1: When `req_low_active` is 0, a request line counts as asserted while it is high. When it is 1, a request line counts as asserted while it is low.
- R2: When `ack_low_active` is 0, an asserted acknowledge drives its pin to 1 and a negated acknowledge drives 0. When it is 1, both levels are inverted.
- R3: Each request passes through `SYNC_STAGES` flip-flops before the arbiter sees it. With the arbiter idle, an acknowledge appears exactly `SYNC_STAGES`+1 clock edges after a request is applied.
- R4: At most one acknowledge is asserted at any time. A new grant goes to the lowest-numbered channel among the synchronized requests.
- R5: A grant is not released when its request is dropped. Only an `xfer_done` pulse, or a preemption under R6, ends a grant.
- R6: The timing mode is non-compatible when `timing_compat` is 0. In that mode, if another channel is requesting once the grant timer has reached `PREEMPT_CYCLES`, the acknowledge is negated. The acknowledge has then been asserted for exactly `PREEMPT_CYCLES`+1 cycles.
- R7: While `timing_compat` is 1, no preemption happens, however long the grant lasts and whichever other channels are waiting.
- R8: A preempted channel has its bit in `resume_pend` set. The bit stays set through the channel's next grant and clears on the clock edge that ends a grant of that channel with `xfer_done`.
- R9: While reset is asserted, every acknowledge pin sits at its negated level.
- R10: In non-compatible mode, a grant with no other channel waiting continues past the timer limit.
- R11: After a grant ends, all acknowledges are negated for at least one cycle before the next grant begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_raw | input | NUM_CH | Raw, asynchronous request lines |
| req_low_active | input | 1 | Request polarity: 0 = active high, 1 = active low |
| ack_low_active | input | 1 | Acknowledge polarity: 0 = active high, 1 = active low |
| timing_compat | input | 1 | 1 = compatible timing mode (fairness timer off) |
| xfer_done | input | 1 | Transfer for the granted channel is complete |
| ack_out | output | NUM_CH | Acknowledge lines, driven at the programmed level |
| resume_pend | output | NUM_CH | Per-channel flag: a preempted transfer is still unfinished |

## Verification
The random part of the bench draws request masks from every non-empty combination of the four channels, under all four polarity pairings and both timing modes. This shows whether the winner follows priority order rather than arrival order, and whether the polarity inversion is applied at both the request side and the acknowledge side. Directed sequences then separate the three ways a grant can end or persist: a dropped request, which must not end it; a timer expiry with a rival waiting, which must end it in non-compatible mode only; and a timer expiry with no rival, which must not end it. A preempted channel is followed through another channel's grant and its own later grant, to show that its resume flag survives the first and is cleared only when its own transfer completes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic {
      ARB_IDLE  = 1'b0,
      ARB_GRANT = 1'b1
   } arb_state_e;

endpackage

// File: rtl/dma_req_cond.sv
module dma_req_cond #(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_raw,
   input  logic              req_low_active,
   output logic [NUM_CH-1:0] req_sync
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dma_req_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_CH-1:0] req_norm;

   // Normalise polarity before the synchronizer so reset value 0 means idle
   assign req_norm = req_raw ^ {NUM_CH{req_low_active}};

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [SYNC_STAGES-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q <= {stage_q[SYNC_STAGES-2:0], req_norm[ch]};
            end
         end
         assign req_sync[ch] = stage_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH = 4,
   parameter int IDX_W  = 2
) (
   input  logic [NUM_CH-1:0] req,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);

   generate
      if ((1 << IDX_W) < NUM_CH) begin : g_bad_idx
         $error("dma_prio_pick: IDX_W too narrow for NUM_CH");
      end
   endgenerate

   // Lowest channel number has highest priority: scan downward, last hit wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/dma_grant_timer.sv
module dma_grant_timer #(
   parameter int PREEMPT_CYCLES = 33333,
   parameter int CNT_W          = $clog2(PREEMPT_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PREEMPT_CYCLES);

   generate
      if (PREEMPT_CYCLES < 1) begin : g_bad_limit
         $error("dma_grant_timer: PREEMPT_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q == LIMIT);

endmodule

// File: rtl/dma_handshake_arb.sv
module dma_handshake_arb #(
   parameter int NUM_CH         = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int PREEMPT_CYCLES = 33333
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_raw,
   input  logic              req_low_active,
   input  logic              ack_low_active,
   input  logic              timing_compat,
   input  logic              xfer_done,
   output logic [NUM_CH-1:0] ack_out,
   output logic [NUM_CH-1:0] resume_pend
);

   import dma_arb_pkg::*;

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int CNT_W = $clog2(PREEMPT_CYCLES + 1);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("dma_handshake_arb: NUM_CH must be at least 2");
      end
   endgenerate

   logic [NUM_CH-1:0] req_sync;
   logic              pick_found;
   logic [IDX_W-1:0]  pick_idx;
   logic              tmr_expired;
   logic [NUM_CH-1:0] gnt_onehot;
   logic              others_waiting;
   logic              preempt;

   arb_state_e        state_q;
   logic [IDX_W-1:0]  gnt_idx_q;
   logic [NUM_CH-1:0] resume_q;

   dma_req_cond #(
      .NUM_CH     (NUM_CH),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_cond (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_raw       (req_raw),
      .req_low_active(req_low_active),
      .req_sync      (req_sync)
   );

   dma_prio_pick #(
      .NUM_CH(NUM_CH),
      .IDX_W (IDX_W)
   ) u_pick (
      .req  (req_sync),
      .found(pick_found),
      .idx  (pick_idx)
   );

   dma_grant_timer #(
      .PREEMPT_CYCLES(PREEMPT_CYCLES),
      .CNT_W         (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state_q == ARB_IDLE),
      .run    (state_q == ARB_GRANT),
      .expired(tmr_expired)
   );

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         gnt_onehot[i] = (state_q == ARB_GRANT) && (gnt_idx_q == IDX_W'(i));
      end
   end

   assign others_waiting = |(req_sync & ~gnt_onehot);
   assign preempt        = (state_q == ARB_GRANT) && !timing_compat &&
                           tmr_expired && others_waiting;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ARB_IDLE;
         gnt_idx_q <= '0;
         resume_q  <= '0;
      end else begin
         case (state_q)
            ARB_IDLE: begin
               if (pick_found) begin
                  state_q   <= ARB_GRANT;
                  gnt_idx_q <= pick_idx;
               end
            end
            ARB_GRANT: begin
               if (xfer_done) begin
                  state_q             <= ARB_IDLE;
                  resume_q[gnt_idx_q] <= 1'b0;
               end else if (preempt) begin
                  state_q             <= ARB_IDLE;
                  resume_q[gnt_idx_q] <= 1'b1;
               end
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign ack_out     = gnt_onehot ^ {NUM_CH{ack_low_active}};
   assign resume_pend = resume_q;

endmodule

// File: rtl/dma_handshake_arb_chk.sv
module dma_handshake_arb_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ack_out,
   input logic              ack_low_active,
   input logic              timing_compat,
   input logic              xfer_done,
   input logic [NUM_CH-1:0] resume_pend,
   input logic [NUM_CH-1:0] req_sync
);

   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   logic [NUM_CH-1:0] ack_norm;
   logic [NUM_CH-1:0] req_d;
   logic [NUM_CH-1:0] req_d_low;

   assign ack_norm  = ack_out ^ {NUM_CH{ack_low_active}};
   assign req_d_low = req_d & (~req_d + ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= '0;
      else        req_d <= req_sync;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_NEGATED: assert (ack_norm == '0); // R9
      end
   end

   AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_norm)); // R4

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(ack_norm) == '0) && (ack_norm != '0)) |-> (ack_norm == req_d_low)); // R4

   AST_COMPAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (timing_compat && (ack_norm != '0) && !xfer_done) |=> (ack_norm == $past(ack_norm))); // R7

   AST_PREEMPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_norm != '0) && !xfer_done) |=>
         ((ack_norm == $past(ack_norm)) || ((resume_pend & $past(ack_norm)) != '0))); // R8

   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_norm != '0) && xfer_done) |=>
         ((ack_norm == '0) && ((resume_pend & $past(ack_norm)) == '0))); // R11

endmodule

bind dma_handshake_arb dma_handshake_arb_chk #(
   .NUM_CH(NUM_CH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ack_out       (ack_out),
   .ack_low_active(ack_low_active),
   .timing_compat (timing_compat),
   .xfer_done     (xfer_done),
   .resume_pend   (resume_pend),
   .req_sync      (req_sync)
);

// File: tb/dma_handshake_arb_tb.sv
module dma_handshake_arb_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int SYNC       = 2;
   localparam int LIMIT      = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] req_raw = '0;
   logic           req_low_active = 1'b0;
   logic           ack_low_active = 1'b0;
   logic           timing_compat = 1'b1;
   logic           xfer_done = 1'b0;
   logic [NCH-1:0] ack_out;
   logic [NCH-1:0] resume_pend;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_handshake_arb #(
      .NUM_CH        (NCH),
      .SYNC_STAGES   (SYNC),
      .PREEMPT_CYCLES(LIMIT)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_raw       (req_raw),
      .req_low_active(req_low_active),
      .ack_low_active(ack_low_active),
      .timing_compat (timing_compat),
      .xfer_done     (xfer_done),
      .ack_out       (ack_out),
      .resume_pend   (resume_pend)
   );

   function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] m);
      for (int i = 0; i < NCH; i++) if (m[i]) return NCH'(1) << i;
      return '0;
   endfunction

   function automatic logic [NCH-1:0] raw_of(input logic [NCH-1:0] m, input logic pol);
      return pol ? ~m : m;
   endfunction

   function automatic logic [NCH-1:0] ack_act();
      return ack_out ^ {NCH{ack_low_active}};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_req(input logic [NCH-1:0] m);
      req_raw = raw_of(m, req_low_active);
   endtask

   task automatic pulse_done();
      xfer_done = 1'b1;
      tick(1);
      xfer_done = 1'b0;
   endtask

   task automatic wait_ack(output int waited);
      waited = 0;
      while (ack_act() == '0 && waited < 40) begin
         tick(1);
         waited++;
      end
   endtask

   task automatic drain();
      set_req('0);
      for (int i = 0; i < 30; i++) begin
         xfer_done = (ack_act() != '0);
         tick(1);
      end
      xfer_done = 1'b0;
      tick(1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int w;
      int hi;
      logic [NCH-1:0] m;
      void'($urandom(32'd5813));

      // R9 / R2: reset level under both acknowledge polarities
      tick(2);
      check(ack_out == 4'h0, "R9 reset ack high-active", ack_out, 0);
      ack_low_active = 1'b1;
      tick(1);
      check(ack_out == 4'hF, "R9 R2 reset ack low-active", ack_out, 4'hF);
      ack_low_active = 1'b0;
      rst_n = 1'b1;
      tick(3);

      // R3: latency through the synchronizer
      set_req(4'b0100);
      w = 0;
      while (ack_act() == '0 && w < 20) begin
         tick(1);
         w++;
      end
      check(w == SYNC + 1, "R3 request-to-ack latency", w, SYNC + 1);
      check(ack_out == 4'b0100, "R4 single requester ch2", ack_out, 4'b0100);

      // R5: request dropped early, grant kept until done
      set_req('0);
      tick(20);
      check(ack_act() == 4'b0100, "R5 grant kept after request drop", ack_act(), 4'b0100);
      pulse_done();
      check(ack_act() == '0, "R11 release on done", ack_act(), 0);
      drain();

      // R1: active-low requests
      req_low_active = 1'b1;
      req_raw = 4'b1111;
      tick(4);
      check(ack_act() == '0, "R1 all-high raw idle when low-active", ack_act(), 0);
      req_raw = 4'b1101;
      wait_ack(w);
      check(ack_act() == 4'b0010, "R1 low-active ch1 granted", ack_act(), 4'b0010);
      drain();
      req_low_active = 1'b0;
      req_raw = '0;
      tick(4);

      // R6 / R8: preemption in non-compatible mode
      timing_compat = 1'b0;
      set_req(4'b0100);
      wait_ack(w);
      set_req(4'b0101);
      hi = 1;
      for (int i = 0; i < 40; i++) begin
         tick(1);
         if (ack_act() != 4'b0100) break;
         hi++;
      end
      check(hi == LIMIT + 1, "R6 grant length before preemption", hi, LIMIT + 1);
      check(ack_act() == '0, "R11 idle cycle after preemption", ack_act(), 0);
      check(resume_pend == 4'b0100, "R8 resume flag set on preemption", resume_pend, 4'b0100);
      tick(1);
      check(ack_act() == 4'b0001, "R4 waiting ch0 wins next", ack_act(), 4'b0001);
      set_req(4'b0100);
      tick(3);
      pulse_done();
      wait_ack(w);
      check(ack_act() == 4'b0100, "R8 preempted ch2 resumes", ack_act(), 4'b0100);
      check(resume_pend == 4'b0100, "R8 flag held during resumed grant", resume_pend, 4'b0100);
      set_req('0);
      pulse_done();
      check(resume_pend == '0, "R8 flag cleared on completion", resume_pend, 0);
      drain();

      // R10: no rival, non-compatible mode, grant outlives the timer
      set_req(4'b0010);
      wait_ack(w);
      tick(3 * LIMIT);
      check(ack_act() == 4'b0010, "R10 lone grant survives timer", ack_act(), 4'b0010);
      drain();

      // R7: compatible mode, rival waiting, no preemption
      timing_compat = 1'b1;
      set_req(4'b1000);
      wait_ack(w);
      set_req(4'b1001);
      tick(4 * LIMIT);
      check(ack_act() == 4'b1000, "R7 no preemption in compatible mode", ack_act(), 4'b1000);
      check(resume_pend == '0, "R7 no resume flag in compatible mode", resume_pend, 0);
      drain();

      // Random rounds: R1 R2 R4 R11
      for (int r = 0; r < 40; r++) begin
         m = NCH'($urandom_range(1, 15));
         req_low_active = 1'($urandom_range(0, 1));
         ack_low_active = 1'($urandom_range(0, 1));
         timing_compat  = 1'($urandom_range(0, 1));
         set_req('0);
         tick(4);
         check(ack_out == {NCH{ack_low_active}}, "R2 idle acknowledge level",
               ack_out, {NCH{ack_low_active}});
         set_req(m);
         wait_ack(w);
         check(ack_act() == lowest(m), "R4 lowest requester wins", ack_act(), lowest(m));
         check(ack_out == (lowest(m) ^ {NCH{ack_low_active}}), "R2 asserted ack level",
               ack_out, lowest(m) ^ {NCH{ack_low_active}});
         tick($urandom_range(0, 5));
         check(ack_act() == lowest(m), "R5 grant held before done", ack_act(), lowest(m));
         pulse_done();
         check(ack_act() == '0, "R11 gap after done", ack_act(), 0);
         drain();
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule